// File: doc/BRIEF.md
# Grouped GPIO Interrupt Controller

This block turns a wide bank of general-purpose input pins into eight interrupt groups that share a single interrupt line. The pins form one flattened vector of `NUM_PORTS * PORT_W` bits (four 32-bit ports by default). The vector is split into byte lanes of eight pins. Group `g` can watch bit `g` of any lane. A 4-bit selector per group picks the lane. A 3-bit trigger code per group sets how the chosen pin raises the group's pending bit: never, while high, while low, always, or on a rising, falling or either edge.

Edge triggers latch a sticky pending bit, which software clears by writing ones to an acknowledge location. Level and forced triggers report the live condition. A per-group enable mask gates the pending bits. The registered OR of the gated bits drives `irq_o`. All pins pass through a two-flop synchroniser before any selection. When a group's trigger code or lane selector changes, that group re-arms its edge detector, so the switch itself is never taken for an edge. Lanes past the implemented pin count read as a constant zero input.

Software uses a plain 32-bit register bus. A write takes effect on the clock edge where `bus_we` is high. Read data is combinational from `bus_addr`.

Top module: `gpio_irq_groups`

## Requirements
- R1: After reset, the trigger register, the lane-select register, the mask, the raw status and the masked status all read zero, and `irq_o` is low.
- R2: The byte addresses are 0x78 for trigger codes, 0x7C for lane select, 0x80 for the mask, 0x84 for acknowledge, 0x88 for raw status and 0x8C for masked status. The trigger code of group g occupies bits [3g+2:3g], and bits 31:24 read 0. The lane of group g occupies bits [4g+3:4g]. The mask uses bits 7:0. Acknowledge and every other address read 0.
- R3: Group g watches bit (lane*8 + g) of the flattened pin vector, where port p pin n is bit p*32+n. Pins outside the selected lane do not affect the group.
- R4: A pin change driven before rising edge k shows up in the raw status of a level-triggered group after edge k+1, and not after edge k.
- R5: Code 1 makes the group pending while its pin is high, and code 2 while it is low. Neither code latches: the bit follows the pin.
- R6: Code 3 keeps the group pending at all times. Codes 0 and 4 never make it pending.
- R7: Codes 5, 6 and 7 set a sticky pending bit on a rising, falling or either edge of the synchronised pin. The bit stays set after the pin returns to its earlier level.
- R8: Writing 1 to bit g at 0x84 clears group g's sticky bit, and zero bits have no effect. An edge detected in the same cycle as the acknowledge still leaves the bit set. An acknowledge has no lasting effect on a level or forced group whose condition still holds.
- R9: When a write changes a group's trigger code or lane, no edge is detected for that group on the following clock edge. The group is re-armed from the new pin's current level.
- R10: Masked status equals raw status AND the mask. With the mask all zero, `irq_o` is low from the next cycle on.
- R11: `irq_o` is the OR of the masked status, registered once. It rises one cycle after the masked status becomes non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NUM_PORTS*PORT_W | Asynchronous GPIO input levels, flattened by port |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The embedded properties check four things on every cycle: the register reset values, that a sticky bit is only ever set under an edge code, that a group being re-armed keeps its sticky bit unchanged, and that `irq_o` follows the gated status one cycle later. Lane routing, the two-edge synchroniser latency, the level codes tracking the pin, and an acknowledge landing in the same cycle as a fresh edge can only be shown by the bench. It does this with timed scenarios and a behavioural model that is compared with the read data and the interrupt on every clock.

// File: rtl/gig_pkg.sv
package gig_pkg;

    localparam int GROUPS    = 8;
    localparam int MODE_W    = 3;
    localparam int LANE_W    = 4;
    localparam int LANE_PINS = 8;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int MODE_BITS = GROUPS * MODE_W;
    localparam int SEL_BITS  = GROUPS * LANE_W;

    localparam logic [ADDR_W-1:0] OFS_TRIG = 8'h78;
    localparam logic [ADDR_W-1:0] OFS_LANE = 8'h7C;
    localparam logic [ADDR_W-1:0] OFS_MASK = 8'h80;
    localparam logic [ADDR_W-1:0] OFS_ACK  = 8'h84;
    localparam logic [ADDR_W-1:0] OFS_RAW  = 8'h88;
    localparam logic [ADDR_W-1:0] OFS_GATE = 8'h8C;

    typedef enum logic [MODE_W-1:0] {
        TRIG_OFF   = 3'd0,
        TRIG_HIGH  = 3'd1,
        TRIG_LOW   = 3'd2,
        TRIG_FORCE = 3'd3,
        TRIG_RSVD  = 3'd4,
        TRIG_RISE  = 3'd5,
        TRIG_FALL  = 3'd6,
        TRIG_BOTH  = 3'd7
    } trig_e;

    typedef struct packed {
        trig_e             mode;
        logic [LANE_W-1:0] lane;
    } slot_cfg_t;

    function automatic logic trig_is_edge(input trig_e m);
        return m[2] && (m[1:0] != 2'b00);
    endfunction

    function automatic logic trig_level(input trig_e m, input logic v);
        case (m)
            TRIG_HIGH:  return v;
            TRIG_LOW:   return !v;
            TRIG_FORCE: return 1'b1;
            default:    return 1'b0;
        endcase
    endfunction

    function automatic logic trig_edge(input trig_e m, input logic p, input logic c);
        case (m)
            TRIG_RISE: return c && !p;
            TRIG_FALL: return p && !c;
            TRIG_BOTH: return p ^ c;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gig_sync.sv
module gig_sync #(
    parameter int WIDTH = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/gig_regs.sv
module gig_regs
    import gig_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   we,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [GROUPS-1:0]      raw_i,
    output slot_cfg_t [GROUPS-1:0] cfg_o,
    output logic [GROUPS-1:0]      mask_o,
    output logic [GROUPS-1:0]      ack_o,
    output logic [GROUPS-1:0]      rearm_o,
    output logic [DATA_W-1:0]      rdata_o
);
    logic [MODE_BITS-1:0] mode_q;
    logic [SEL_BITS-1:0]  sel_q;
    logic [GROUPS-1:0]    mask_q;
    logic                 wr_trig, wr_lane;
    logic [GROUPS-1:0]    mode_chg, sel_chg;

    assign wr_trig = we && (addr == OFS_TRIG);
    assign wr_lane = we && (addr == OFS_LANE);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            sel_q  <= '0;
            mask_q <= '0;
        end else if (we) begin
            case (addr)
                OFS_TRIG: mode_q <= wdata[MODE_BITS-1:0];
                OFS_LANE: sel_q  <= wdata[SEL_BITS-1:0];
                OFS_MASK: mask_q <= wdata[GROUPS-1:0];
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_field
        assign cfg_o[g] = '{mode: trig_e'(mode_q[g*MODE_W +: MODE_W]),
                            lane: sel_q[g*LANE_W +: LANE_W]};
        assign mode_chg[g] = wr_trig &&
                             (wdata[g*MODE_W +: MODE_W] != mode_q[g*MODE_W +: MODE_W]);
        assign sel_chg[g]  = wr_lane &&
                             (wdata[g*LANE_W +: LANE_W] != sel_q[g*LANE_W +: LANE_W]);
    end

    assign rearm_o = mode_chg | sel_chg;
    assign ack_o   = (we && (addr == OFS_ACK)) ? wdata[GROUPS-1:0] : '0;
    assign mask_o  = mask_q;

    always_comb begin
        case (addr)
            OFS_TRIG: rdata_o = DATA_W'(mode_q);
            OFS_LANE: rdata_o = DATA_W'(sel_q);
            OFS_MASK: rdata_o = DATA_W'(mask_q);
            OFS_RAW:  rdata_o = DATA_W'(raw_i);
            OFS_GATE: rdata_o = DATA_W'(raw_i & mask_q);
            default:  rdata_o = '0;
        endcase
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mode_q == '0 && sel_q == '0 && mask_q == '0));
endmodule

// File: rtl/gig_slot.sv
module gig_slot
    import gig_pkg::*;
#(
    parameter int G     = 0,
    parameter int PIN_N = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIN_N-1:0] pins,
    input  slot_cfg_t        cfg,
    input  logic             ack,
    input  logic             rearm,
    output logic             raw
);
    localparam int LANES      = PIN_N / LANE_PINS;
    localparam int LANE_SLOTS = 2 ** LANE_W;

    logic [LANE_SLOTS-1:0] lane_bits;
    logic                  cur, prev_q, armed_q, sticky_q, hit;

    for (genvar l = 0; l < LANE_SLOTS; l++) begin : g_lane
        if (l < LANES) begin : g_real
            assign lane_bits[l] = pins[l*LANE_PINS + G];
        end else begin : g_void
            assign lane_bits[l] = 1'b0;
        end
    end

    assign cur = lane_bits[cfg.lane];
    assign hit = armed_q && trig_edge(cfg.mode, prev_q, cur);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= 1'b0;
            armed_q  <= 1'b0;
            sticky_q <= 1'b0;
        end else begin
            prev_q   <= cur;
            armed_q  <= !rearm;
            sticky_q <= (sticky_q && !ack) || hit;
        end
    end

    assign raw = trig_is_edge(cfg.mode) ? sticky_q : trig_level(cfg.mode, cur);

    // R9
    rearm_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!armed_q && !ack) |=> $stable(sticky_q));

    // R7
    sticky_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sticky_q) |-> trig_is_edge($past(cfg.mode)));
endmodule

// File: rtl/gpio_irq_groups.sv
module gpio_irq_groups
    import gig_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_PORTS*PORT_W-1:0] pins_i,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_we,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic                        irq_o
);
    localparam int PIN_N = NUM_PORTS * PORT_W;

    logic [PIN_N-1:0]       pins_s;
    slot_cfg_t [GROUPS-1:0] cfg;
    logic [GROUPS-1:0]      mask, ack, rearm, raw;
    logic                   irq_q;

    gig_sync #(.WIDTH(PIN_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_i),
        .q   (pins_s)
    );

    gig_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (bus_addr),
        .we      (bus_we),
        .wdata   (bus_wdata),
        .raw_i   (raw),
        .cfg_o   (cfg),
        .mask_o  (mask),
        .ack_o   (ack),
        .rearm_o (rearm),
        .rdata_o (bus_rdata)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_slot
        gig_slot #(.G(g), .PIN_N(PIN_N)) u_slot (
            .clk   (clk),
            .rst   (rst),
            .pins  (pins_s),
            .cfg   (cfg[g]),
            .ack   (ack[g]),
            .rearm (rearm[g]),
            .raw   (raw[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(raw & mask);
    end

    assign irq_o = irq_q;

    // R10
    mask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |=> !irq_o);

    // R11
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (|(raw & mask)) |=> irq_o);
endmodule

// File: tb/gpio_irq_groups_bench.sv
module gpio_irq_groups_bench;
    localparam int NP  = 4;
    localparam int PW  = 32;
    localparam int PN  = NP * PW;
    localparam int CYC = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [PN-1:0] pins = '0;
    logic [7:0]    addr = 8'h00;
    logic          we = 1'b0;
    logic [31:0]   wdata = '0;
    wire  [31:0]   rdata;
    wire           irq;
    int            total = 0;
    int            bad = 0;
    bit            done = 1'b0;

    always #(CYC/2) clk = ~clk;

    gpio_irq_groups #(.NUM_PORTS(NP), .PORT_W(PW)) u_gpio_irq_groups (
        .clk       (clk),
        .rst       (rst),
        .pins_i    (pins),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq_o     (irq)
    );

    // behavioural reference state
    logic [PN-1:0] m_s1, m_s2;
    logic [7:0]    m_prev, m_armed, m_sticky, m_mask;
    logic [23:0]   m_mode;
    logic [31:0]   m_sel;
    logic          m_irq;

    function automatic logic m_cur(input int g);
        int idx;
        idx = int'(m_sel[4*g +: 4]) * 8 + g;
        return (idx < PN) ? m_s2[idx] : 1'b0;
    endfunction

    function automatic logic [7:0] m_raw();
        logic [7:0] r;
        for (int g = 0; g < 8; g++) begin
            case (m_mode[3*g +: 3])
                3'd1:             r[g] = m_cur(g);
                3'd2:             r[g] = !m_cur(g);
                3'd3:             r[g] = 1'b1;
                3'd5, 3'd6, 3'd7: r[g] = m_sticky[g];
                default:          r[g] = 1'b0;
            endcase
        end
        return r;
    endfunction

    function automatic logic [31:0] m_rd(input logic [7:0] a);
        case (a)
            8'h78:   return {8'h00, m_mode};
            8'h7C:   return m_sel;
            8'h80:   return {24'h0, m_mask};
            8'h88:   return {24'h0, m_raw()};
            8'h8C:   return {24'h0, m_raw() & m_mask};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic [7:0] raw, hit, nprev, ackv, rearm;
        logic       c, p, e;
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_armed = '0; m_sticky = '0;
            m_mask = '0; m_mode = '0; m_sel = '0; m_irq = 1'b0;
        end else begin
            raw = m_raw();
            for (int g = 0; g < 8; g++) begin
                c = m_cur(g);
                p = m_prev[g];
                case (m_mode[3*g +: 3])
                    3'd5:    e = c && !p;
                    3'd6:    e = p && !c;
                    3'd7:    e = p != c;
                    default: e = 1'b0;
                endcase
                hit[g]   = m_armed[g] && e;
                nprev[g] = c;
                rearm[g] = we && (((addr == 8'h78) && (wdata[3*g +: 3] != m_mode[3*g +: 3])) ||
                                  ((addr == 8'h7C) && (wdata[4*g +: 4] != m_sel[4*g +: 4])));
            end
            ackv     = (we && addr == 8'h84) ? wdata[7:0] : 8'h00;
            m_irq    = |(raw & m_mask);
            m_sticky = (m_sticky & ~ackv) | hit;
            m_prev   = nprev;
            m_armed  = ~rearm;
            m_s2     = m_s1;
            m_s1     = pins;
            if (we) begin
                case (addr)
                    8'h78: m_mode = wdata[23:0];
                    8'h7C: m_sel  = wdata;
                    8'h80: m_mask = wdata[7:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        #2;
        if (!rst && !done) begin
            chk("R2 per-cycle read data", rdata, m_rd(addr));
            chk("R11 per-cycle irq", {31'h0, irq}, {31'h0, m_irq});
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #2;
        chk(tag, rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setpin(input int idx, input logic v);
        @(negedge clk);
        pins[idx] = v;
    endtask

    initial begin
        idle(4);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        rd_chk(8'h78, 0, "R1 trigger reg");
        rd_chk(8'h7C, 0, "R1 lane reg");
        rd_chk(8'h80, 0, "R1 mask reg");
        rd_chk(8'h88, 0, "R1 raw status");
        rd_chk(8'h8C, 0, "R1 masked status");
        chk("R1 irq low", {31'h0, irq}, 32'h0);

        // R2 register map and field widths
        wr(8'h78, 32'hFFFF_FFFF); rd_chk(8'h78, 32'h00FF_FFFF, "R2 trigger width");
        wr(8'h7C, 32'hA5A5_A5A5); rd_chk(8'h7C, 32'hA5A5_A5A5, "R2 lane readback");
        wr(8'h80, 32'h0000_01FF); rd_chk(8'h80, 32'h0000_00FF, "R2 mask width");
        rd_chk(8'h84, 0, "R2 ack reads zero");
        rd_chk(8'h00, 0, "R2 unmapped reads zero");
        wr(8'h80, 0); wr(8'h7C, 0); wr(8'h78, 0);

        // R3 and R5: group 3 on lane 5 (pin 43), high level
        wr(8'h7C, 32'h5 << 12);
        wr(8'h78, 32'h1 << 9);
        setpin(3, 1'b1); idle(3);
        rd_chk(8'h88, 0, "R3 unselected lane ignored");
        setpin(43, 1'b1); idle(3);
        rd_chk(8'h88, 32'h08, "R3 routed pin seen");
        rd_chk(8'h88, 32'h08, "R5 high level pending");
        wr(8'h78, 32'h2 << 9);
        rd_chk(8'h88, 0, "R5 low level quiet while high");
        setpin(43, 1'b0); idle(3);
        rd_chk(8'h88, 32'h08, "R5 low level pending");
        setpin(43, 1'b1); idle(3);
        rd_chk(8'h88, 0, "R5 level not latched");
        wr(8'h78, 0); wr(8'h7C, 0); setpin(3, 1'b0); setpin(43, 1'b0); idle(3);

        // R6 forced, reserved, off
        wr(8'h78, 32'h3); rd_chk(8'h88, 32'h01, "R6 forced pending");
        wr(8'h78, 32'h4); rd_chk(8'h88, 0, "R6 reserved code quiet");
        wr(8'h78, 32'h0); rd_chk(8'h88, 0, "R6 off quiet");

        // R7 edges on group 1 (pin 1), R8 acknowledge
        wr(8'h78, 32'h5 << 3);
        setpin(1, 1'b1); idle(3);
        rd_chk(8'h88, 32'h02, "R7 rising latched");
        setpin(1, 1'b0); idle(3);
        rd_chk(8'h88, 32'h02, "R7 sticky after pin drops");
        wr(8'h84, 32'h02);
        rd_chk(8'h88, 0, "R8 ack clears sticky");
        wr(8'h78, 32'h6 << 3);
        setpin(1, 1'b1); idle(3);
        rd_chk(8'h88, 0, "R7 falling ignores rise");
        setpin(1, 1'b0); idle(3);
        rd_chk(8'h88, 32'h02, "R7 falling latched");
        wr(8'h84, 32'h02);
        wr(8'h78, 32'h7 << 3);
        setpin(1, 1'b1); idle(3);
        rd_chk(8'h88, 32'h02, "R7 either edge on rise");
        wr(8'h84, 32'h02);
        setpin(1, 1'b0); idle(3);
        rd_chk(8'h88, 32'h02, "R7 either edge on fall");
        wr(8'h84, 32'hFD);
        rd_chk(8'h88, 32'h02, "R8 zero bits no effect");
        wr(8'h84, 32'h02); wr(8'h78, 0);

        // R8 ack on a held level
        wr(8'h78, 32'h1 << 6);
        setpin(2, 1'b1); idle(3);
        wr(8'h84, 32'h04);
        rd_chk(8'h88, 32'h04, "R8 ack no lasting effect on level");
        wr(8'h78, 0); setpin(2, 1'b0);

        // R8 edge and ack in the same cycle: group 4 rising
        wr(8'h78, 32'h5 << 12);
        idle(3);
        setpin(4, 1'b1);
        @(negedge clk);
        wr(8'h84, 32'h10);
        rd_chk(8'h88, 32'h10, "R8 edge wins over ack");
        wr(8'h84, 32'h10);
        rd_chk(8'h88, 0, "R8 later ack clears");
        setpin(4, 1'b0); wr(8'h78, 0);

        // R9 re-arm on lane change: group 5 rising, pin 45 held high
        wr(8'h78, 32'h5 << 15);
        setpin(45, 1'b1); idle(3);
        rd_chk(8'h88, 0, "R9 other lane not yet selected");
        wr(8'h7C, 32'h5 << 20); idle(3);
        rd_chk(8'h88, 0, "R9 lane change is no edge");
        setpin(45, 1'b0); setpin(45, 1'b1); idle(3);
        rd_chk(8'h88, 32'h20, "R9 real edge after re-arm");
        wr(8'h84, 32'h20);

        // R4 synchroniser latency: group 6 high level on pin 6
        wr(8'h78, 32'h1 << 18);
        @(negedge clk); addr = 8'h88;
        setpin(6, 1'b1);
        @(negedge clk); #2;
        chk("R4 not visible after one edge", {31'h0, rdata[6]}, 32'h0);
        @(negedge clk); #2;
        chk("R4 visible after two edges", {31'h0, rdata[6]}, 32'h1);

        // R10 / R11 mask and interrupt timing, group 0 forced
        wr(8'h78, 32'h3);
        rd_chk(8'h8C, 0, "R10 masked off");
        chk("R10 irq low with empty mask", {31'h0, irq}, 32'h0);
        @(negedge clk); addr = 8'h80; wdata = 32'h1; we = 1'b1;
        @(negedge clk); we = 1'b0; addr = 8'h8C; #2;
        chk("R10 masked status follows mask", rdata, 32'h1);
        chk("R11 one cycle latency", {31'h0, irq}, 32'h0);
        @(negedge clk); #2;
        chk("R11 irq raised", {31'h0, irq}, 32'h1);
        wr(8'h80, 0); idle(2);
        chk("R10 irq drops after unmask", {31'h0, irq}, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CYC * 50000);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule